// File: doc/BRIEF.md
# Horizontally Microcoded Bus Datapath

This block is the execution half of a hard-wired processor. It has no sequencer of its own. An external controller presents one wide control word every clock cycle. Each field of that word drives a single unit or bus driver directly: register-file addresses and output enables, a general register, a loadable up-counter, an ALU, a barrel shifter and an output port register. The block performs the operations that the word names and stores the results at the next rising edge.

Two operand buses (A and B) and one result bus connect the units. They are built as multiplexers and not as tri-state lines. Bus A is fed from register-file read port 2 or from the general register. Bus B is fed from read port 1 or from the counter. The ALU and the comparator both read A and B, so they always see the same pair of values. The shifter reads bus A. The ALU or the shifter drives the result bus, never both together. The register-file write port takes either the result bus or the external input, and the input reaches no other unit.

A combinational error flag shows when a control word enables two drivers onto the same bus, or asks the counter to load and count in the same cycle. The bus value in that cycle is not defined.

Top module: `mcdp_core`

## Requirements
- R1: An active-low reset clears all eight register-file entries, the general register, the counter and the output port to zero.
- R2: When `wr_en` is set, the entry at `wr_addr` takes `in_data` if `wr_src`=1 or the result bus if `wr_src`=0, at the rising edge. Reads are combinational, so a read of that address in the same cycle returns the previous contents.
- R3: Bus A carries read port 2 (`rd2_addr`) when `rd2_oe` is set, otherwise the general register when `reg_oe` is set, otherwise zero. Bus B carries read port 1 (`rd1_addr`) when `rd1_oe` is set, otherwise the counter when `cnt_oe` is set, otherwise zero.
- R4: The ALU computes modulo 2^DATA_W on the field `alu_fn`: 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 A, 6 B, 7 NOT A.
- R5: The shifter produces bus A shifted left logically by `sh_amt` (0..7), with zeros filled in.
- R6: The result bus carries the ALU output when `alu_oe` is set, otherwise the shifter output when `sh_oe` is set, otherwise zero. `reg_ld` loads it into the general register and `out_ld` loads it into the output port. The output port holds its value when `out_ld` is clear.
- R7: The counter clears on `cnt_clr`, which has priority. Otherwise it loads the result bus on `cnt_ld`, otherwise it adds one on `cnt_inc`, wrapping from all-ones to zero.
- R8: `cmp_gt`, `cmp_eq` and `cmp_lt` compare bus A against bus B as unsigned values in the same cycle, and exactly one of them is high.
- R9: `bus_err` is high in any cycle where `rd2_oe`&`reg_oe`, `rd1_oe`&`cnt_oe`, `alu_oe`&`sh_oe` or `cnt_ld`&`cnt_inc` are both set. It is low for every other word.

Control word fields, from bit 0 upward: `wr_en`[0], `wr_addr`[3:1], `wr_src`[4], `rd1_addr`[7:5], `rd1_oe`[8], `rd2_addr`[11:9], `rd2_oe`[12], `reg_oe`[13], `reg_ld`[14], `cnt_oe`[15], `cnt_clr`[16], `cnt_ld`[17], `cnt_inc`[18], `alu_fn`[21:19], `alu_oe`[22], `sh_amt`[25:23], `sh_oe`[26], `out_ld`[27].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 28 | Horizontal control word, fields as listed above |
| in_data | input | DATA_W | External input, written only into the register file |
| out_data | output | DATA_W | Output port register |
| cmp_gt | output | 1 | Bus A greater than bus B |
| cmp_eq | output | 1 | Bus A equal to bus B |
| cmp_lt | output | 1 | Bus A less than bus B |
| bus_err | output | 1 | Conflicting drivers or counter requests in this word |

## Verification
The bench builds the block with its defaults: DATA_W=8 and eight register entries. At that size every ordered pair of register-file entries can be run through all eight ALU functions and the comparator, and every entry through all eight shift amounts, each against arithmetic done in the bench. The 8-bit width also makes the counter wrap and the subtract borrow cheap to reach. The write-while-read case, the empty result bus and each of the four conflict pairs are driven one at a time.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
    localparam int RF_AW = 3;
    localparam int SH_W  = 3;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_XOR   = 3'd4,
        ALU_PASSA = 3'd5,
        ALU_PASSB = 3'd6,
        ALU_NOTA  = 3'd7
    } alu_fn_e;

    typedef struct packed {
        logic             out_ld;
        logic             sh_oe;
        logic [SH_W-1:0]  sh_amt;
        logic             alu_oe;
        alu_fn_e          alu_fn;
        logic             cnt_inc;
        logic             cnt_ld;
        logic             cnt_clr;
        logic             cnt_oe;
        logic             reg_ld;
        logic             reg_oe;
        logic             rd2_oe;
        logic [RF_AW-1:0] rd2_addr;
        logic             rd1_oe;
        logic [RF_AW-1:0] rd1_addr;
        logic             wr_src;
        logic [RF_AW-1:0] wr_addr;
        logic             wr_en;
    } cw_t;

    localparam int CW_W = $bits(cw_t);
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];
endmodule

// File: rtl/mcdp_counter.sv
module mcdp_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (ld)  q <= d;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_PASSA: y = a;
            ALU_PASSB: y = b;
            ALU_NOTA:  y = ~a;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/mcdp_shifter.sv
module mcdp_shifter #(
    parameter int W  = 8,
    parameter int SW = 3
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  y
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = a;
    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
    end
    assign y = stage[SW];
endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
    import mcdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctl,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              cmp_gt,
    output logic              cmp_eq,
    output logic              cmp_lt,
    output logic              bus_err
);
    cw_t cw;
    assign cw = cw_t'(ctl);

    logic [DATA_W-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [DATA_W-1:0] gpr_q, cnt_q;
    logic [DATA_W-1:0] bus_a, bus_b, res_bus;
    logic [DATA_W-1:0] alu_y, sh_y;

    assign rf_wd = cw.wr_src ? in_data : res_bus;

    mcdp_regfile #(.W(DATA_W), .AW(RF_AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(cw.wr_en), .wa(cw.wr_addr), .wd(rf_wd),
        .ra1(cw.rd1_addr), .ra2(cw.rd2_addr),
        .rd1(rf_rd1), .rd2(rf_rd2)
    );

    mcdp_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(cw.cnt_clr), .ld(cw.cnt_ld), .inc(cw.cnt_inc),
        .d(res_bus), .q(cnt_q)
    );

    always_comb begin
        if (cw.rd2_oe)      bus_a = rf_rd2;
        else if (cw.reg_oe) bus_a = gpr_q;
        else                bus_a = '0;
    end

    always_comb begin
        if (cw.rd1_oe)      bus_b = rf_rd1;
        else if (cw.cnt_oe) bus_b = cnt_q;
        else                bus_b = '0;
    end

    mcdp_alu #(.W(DATA_W)) u_alu (
        .fn(cw.alu_fn), .a(bus_a), .b(bus_b), .y(alu_y)
    );

    mcdp_shifter #(.W(DATA_W), .SW(SH_W)) u_sh (
        .a(bus_a), .amt(cw.sh_amt), .y(sh_y)
    );

    always_comb begin
        if (cw.alu_oe)     res_bus = alu_y;
        else if (cw.sh_oe) res_bus = sh_y;
        else               res_bus = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gpr_q <= '0;
        else if (cw.reg_ld) gpr_q <= res_bus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_data <= '0;
        else if (cw.out_ld) out_data <= res_bus;
    end

    assign cmp_gt = bus_a > bus_b;
    assign cmp_eq = bus_a == bus_b;
    assign cmp_lt = bus_a < bus_b;

    assign bus_err = (cw.rd2_oe & cw.reg_oe) | (cw.rd1_oe & cw.cnt_oe)
                   | (cw.alu_oe & cw.sh_oe)  | (cw.cnt_ld & cw.cnt_inc);
endmodule

// File: rtl/mcdp_chk.sv
module mcdp_chk
    import mcdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input cw_t               cw,
    input logic [DATA_W-1:0] bus_a,
    input logic [DATA_W-1:0] bus_b,
    input logic [DATA_W-1:0] res_bus,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] out_data,
    input logic              cmp_gt,
    input logic              cmp_eq,
    input logic              cmp_lt,
    input logic              bus_err
);
    p_cmp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmp_gt, cmp_eq, cmp_lt}) == 1);

    p_cmp_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_a == bus_b) |-> cmp_eq);

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cw.out_ld |=> $stable(out_data));

    p_out_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cw.out_ld |=> out_data == $past(res_bus));

    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cw.cnt_clr |=> cnt_q == '0);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.cnt_inc && !cw.cnt_clr && !cw.cnt_ld) |=> cnt_q == $past(cnt_q) + DATA_W'(1));

    p_err_busa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.rd2_oe && cw.reg_oe) |-> bus_err);

    p_err_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.alu_oe && cw.sh_oe) |-> bus_err);
endmodule

bind mcdp_core mcdp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cw(cw),
    .bus_a(bus_a), .bus_b(bus_b), .res_bus(res_bus), .cnt_q(cnt_q),
    .out_data(out_data), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt),
    .bus_err(bus_err)
);

// File: tb/mcdp_core_test.sv
`timescale 1ns/1ps
module mcdp_core_test;
    import mcdp_pkg::*;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW_W-1:0] ctl = '0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] out_data;
    logic cmp_gt, cmp_eq, cmp_lt, bus_err;

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] rfv [8];

    always #2.5 clk = ~clk;

    mcdp_core #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .in_data(in_data),
        .out_data(out_data), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq),
        .cmp_lt(cmp_lt), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic cw_t idle();
        cw_t w;
        w = '0;
        return w;
    endfunction

    function automatic logic [W-1:0] alu_ref(input int fn, input logic [W-1:0] a, input logic [W-1:0] b);
        case (fn)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a;
            6: return b;
            default: return ~a;
        endcase
    endfunction

    task automatic apply(input cw_t w, input logic [W-1:0] d);
        @(negedge clk);
        ctl = w;
        in_data = d;
        #1;
    endtask

    task automatic run_out(input cw_t w, output logic [W-1:0] v);
        w.out_ld = 1'b1;
        apply(w, '0);
        @(posedge clk);
        #1;
        v = out_data;
    endtask

    task automatic read_rf(input int a, output logic [W-1:0] v);
        cw_t w;
        w = idle();
        w.rd2_oe = 1'b1; w.rd2_addr = 3'(a);
        w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA;
        run_out(w, v);
    endtask

    task automatic read_cnt(output logic [W-1:0] v);
        cw_t w;
        w = idle();
        w.cnt_oe = 1'b1; w.alu_oe = 1'b1; w.alu_fn = ALU_PASSB;
        run_out(w, v);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        cw_t w;
        logic [W-1:0] v;
        logic [W-1:0] cexp;

        #12;
        check("R1 out after reset", 32'(out_data), 0);
        rst_n = 1'b1;

        // R1: storage zero after reset
        for (int i = 0; i < 8; i++) begin
            read_rf(i, v);
            check("R1 rf entry", 32'(v), 0);
        end
        read_cnt(v);
        check("R1 counter", 32'(v), 0);
        w = idle(); w.reg_oe = 1'b1; w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA;
        run_out(w, v);
        check("R1 general register", 32'(v), 0);

        // R2: fill from input port
        for (int i = 0; i < 8; i++) begin
            rfv[i] = W'(i * 37 + 5);
            w = idle(); w.wr_en = 1'b1; w.wr_src = 1'b1; w.wr_addr = 3'(i);
            apply(w, rfv[i]);
        end
        for (int i = 0; i < 8; i++) begin
            read_rf(i, v);
            check("R2 R3 input write readback", 32'(v), 32'(rfv[i]));
        end

        // R4 R8 R9: all pairs x all functions
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int f = 0; f < 8; f++) begin
                    w = idle();
                    w.rd2_oe = 1'b1; w.rd2_addr = 3'(i);
                    w.rd1_oe = 1'b1; w.rd1_addr = 3'(j);
                    w.alu_oe = 1'b1; w.alu_fn = alu_fn_e'(f);
                    w.out_ld = 1'b1;
                    apply(w, '0);
                    if (f == 0) begin
                        check("R8 gt", 32'(cmp_gt), 32'(rfv[i] > rfv[j]));
                        check("R8 eq", 32'(cmp_eq), 32'(rfv[i] == rfv[j]));
                        check("R8 lt", 32'(cmp_lt), 32'(rfv[i] < rfv[j]));
                        check("R9 legal word", 32'(bus_err), 0);
                    end
                    @(posedge clk); #1;
                    check("R4 alu function", 32'(out_data), 32'(alu_ref(f, rfv[i], rfv[j])));
                end
            end
        end

        // R5: shifter sweep
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 8; s++) begin
                w = idle();
                w.rd2_oe = 1'b1; w.rd2_addr = 3'(i);
                w.sh_oe = 1'b1; w.sh_amt = 3'(s);
                run_out(w, v);
                check("R5 shift left", 32'(v), 32'(W'(rfv[i] << s)));
            end
        end

        // R2: same-cycle read returns old, then new
        w = idle();
        w.wr_en = 1'b1; w.wr_src = 1'b1; w.wr_addr = 3'd0;
        w.rd2_oe = 1'b1; w.rd2_addr = 3'd0;
        w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA; w.out_ld = 1'b1;
        apply(w, 8'hAA);
        @(posedge clk); #1;
        check("R2 read during write old", 32'(out_data), 32'(rfv[0]));
        rfv[0] = 8'hAA;
        read_rf(0, v);
        check("R2 written value", 32'(v), 32'hAA);

        // R2: write from result bus
        w = idle();
        w.rd2_oe = 1'b1; w.rd2_addr = 3'd3; w.rd1_oe = 1'b1; w.rd1_addr = 3'd4;
        w.alu_oe = 1'b1; w.alu_fn = ALU_ADD;
        w.wr_en = 1'b1; w.wr_addr = 3'd7;
        apply(w, 8'h55);
        read_rf(7, v);
        check("R2 result bus write", 32'(v), 32'(W'(rfv[3] + rfv[4])));
        rfv[7] = v;

        // R6 R3: general register
        w = idle();
        w.rd2_oe = 1'b1; w.rd2_addr = 3'd2; w.alu_oe = 1'b1; w.alu_fn = ALU_NOTA;
        w.reg_ld = 1'b1;
        apply(w, '0);
        w = idle(); w.reg_oe = 1'b1; w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA;
        run_out(w, v);
        check("R6 R3 general register", 32'(v), 32'(W'(~rfv[2])));

        // R6: output hold and empty result bus
        w = idle(); w.rd2_oe = 1'b1; w.rd2_addr = 3'd5; w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA;
        apply(w, '0);
        @(posedge clk); #1;
        check("R6 hold without out_ld", 32'(out_data), 32'(W'(~rfv[2])));
        w = idle();
        run_out(w, v);
        check("R6 idle result bus", 32'(v), 0);

        // R3: undriven operand buses compare equal
        apply(idle(), '0);
        check("R3 R8 idle buses equal", 32'(cmp_eq), 1);

        // R7: counter
        w = idle(); w.rd2_oe = 1'b1; w.rd2_addr = 3'd1; w.alu_oe = 1'b1; w.alu_fn = ALU_PASSA;
        w.cnt_ld = 1'b1;
        apply(w, '0);
        cexp = rfv[1];
        for (int k = 0; k < 3; k++) begin
            w = idle(); w.cnt_inc = 1'b1;
            apply(w, '0);
            cexp = cexp + 1'b1;
        end
        read_cnt(v);
        check("R7 load then count", 32'(v), 32'(cexp));
        w = idle(); w.reg_oe = 1'b0; w.rd2_oe = 1'b1; w.rd2_addr = 3'd0;
        w.sh_oe = 1'b1; w.sh_amt = 3'd0; w.cnt_ld = 1'b1; w.cnt_clr = 1'b1;
        apply(w, '0);
        read_cnt(v);
        check("R7 clear beats load", 32'(v), 0);
        w = idle(); w.rd2_oe = 1'b1; w.rd2_addr = 3'd0; w.alu_oe = 1'b1; w.alu_fn = ALU_OR;
        w.rd1_oe = 1'b1; w.rd1_addr = 3'd0;
        apply(w, '0);
        w = idle(); w.alu_oe = 1'b1; w.alu_fn = ALU_NOTA; w.cnt_ld = 1'b1;
        apply(w, '0);
        w = idle(); w.cnt_inc = 1'b1;
        apply(w, '0);
        read_cnt(v);
        check("R7 wrap to zero", 32'(v), 0);

        // R9: each conflict pair
        w = idle(); w.rd2_oe = 1'b1; w.reg_oe = 1'b1; apply(w, '0);
        check("R9 bus A pair", 32'(bus_err), 1);
        w = idle(); w.rd1_oe = 1'b1; w.cnt_oe = 1'b1; apply(w, '0);
        check("R9 bus B pair", 32'(bus_err), 1);
        w = idle(); w.alu_oe = 1'b1; w.sh_oe = 1'b1; apply(w, '0);
        check("R9 result pair", 32'(bus_err), 1);
        w = idle(); w.cnt_ld = 1'b1; w.cnt_inc = 1'b1; apply(w, '0);
        check("R9 counter pair", 32'(bus_err), 1);
        apply(idle(), '0);
        check("R9 idle word", 32'(bus_err), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule